// File: doc/BRIEF.md
# Strand Select Stage

This block is the switch stage of a fine-grained multithreaded in-order core with four hardware strands. It sits after fetch and before decode in a six-stage pipe (fetch, switch, decode, execute, memory, writeback). Each strand has its own instruction register. Fetch fills these registers through a return port. Every cycle the block offers decode the current instruction of one ready strand, tagged with that strand's ID. It picks among ready strands in round-robin order.

When decode accepts the offer, three things happen in that same cycle. The chosen register is drained. A request for that strand's next instruction goes to fetch. The rotation pointer moves to the strand after the winner. A strand whose long-latency instruction was just issued is marked stalled by a later stage. The rotation skips it until a completion pulse for that strand releases it. After release it rejoins the rotation at once.

The decode side is a valid/ready stream. `dec_valid` rises whenever some strand is ready, and a transfer happens on a cycle where both `dec_valid` and `dec_ready` are high. While `dec_ready` is low the pointer does not move and no fetch request is made. The offer stays the same unless a fill, stall mark or completion changes which strands are ready. The fetch return port and the stall/completion pins are plain pulses and are always taken.

Top module: `strand_switch`

## Requirements
- R1: Synchronous active-high reset empties every instruction register, clears every stall mark and sets the rotation pointer to strand 0. Directly after reset `dec_valid` and `req_valid` are 0. If all four registers are then filled before any transfer, strand 0 is offered first.
- R2: A cycle with `fill_valid` high loads `fill_instr` into the register of strand `fill_sid` and marks it full. From the next cycle that strand can be offered, with `dec_instr` equal to the loaded word and `dec_sid` equal to its ID.
- R3: A strand is ready only when its register is full and it is not stalled. When no strand is ready, `dec_valid` is 0.
- R4: The offered strand is the first ready strand found by scanning upward from the rotation pointer, wrapping from 3 to 0. On a transfer the pointer becomes the winner's ID plus one, modulo 4.
- R5: In a cycle without a transfer the pointer does not move and `req_valid` is 0. If no fill, stall mark or completion arrives, the offer (`dec_valid`, `dec_sid`, `dec_instr`) is the same in the next cycle.
- R6: In every transfer cycle `req_valid` is 1 and `req_sid` equals `dec_sid`, asking fetch for that strand's next instruction.
- R7: A transfer empties the winner's register, unless a fill for the same strand arrives in that cycle. In that case the register holds the new word and stays full.
- R8: A `stall_set_valid` pulse marks strand `stall_set_sid` stalled from the next cycle. A stalled strand is never offered.
- R9: A `done_valid` pulse clears the stall mark of strand `done_sid` from the next cycle. If a mark and a completion hit the same strand in one cycle, the completion wins and the strand ends up not stalled.
- R10: A fill for a strand whose register is already full, in a cycle with no transfer of that strand, replaces the held word.
- R11: A released strand whose register is full is ready in the very next cycle and competes in the rotation with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Fetch return pulse |
| fill_sid | input | 2 | Strand the returned word belongs to |
| fill_instr | input | 32 | Returned instruction word |
| stall_set_valid | input | 1 | Mark a strand as waiting on a long-latency event |
| stall_set_sid | input | 2 | Strand to mark |
| done_valid | input | 1 | Long-latency completion pulse |
| done_sid | input | 2 | Strand to release |
| dec_valid | output | 1 | An instruction is offered to decode |
| dec_ready | input | 1 | Decode accepts the offer |
| dec_sid | output | 2 | Strand ID tag of the offer |
| dec_instr | output | 32 | Offered instruction word |
| req_valid | output | 1 | Fetch request for the next instruction |
| req_sid | output | 2 | Strand whose next instruction is requested |

## Verification
The offer-hold property assumes a quiet cycle: the offer may legally change whenever a fill, a stall mark or a completion arrives. The property therefore only checks cycles where all three control inputs are idle. The random stimulus drives each of these pulses at modest rates and holds `dec_ready` low about a third of the time, so stretches of back-pressure with no control activity happen often. The stall-skip and drain properties assume that the strand IDs on the mark, completion and fill ports may name any strand at any time, including strands that are empty or already stalled. The stimulus draws those IDs uniformly to cover that freedom. Directed sequences add the exact corner cases: a simultaneous mark and completion, a fill that coincides with a drain, and a fill that overwrites a held word.

// File: rtl/strand_switch_pkg.sv
package strand_switch_pkg;

  localparam int unsigned DEF_STRANDS = 4;
  localparam int unsigned DEF_INSTR_W = 32;

  // next rotation position after a winner, wrapping at the strand count
  function automatic int unsigned wrap_next(input int unsigned id, input int unsigned count);
    return (id + 1 >= count) ? 0 : id + 1;
  endfunction

endpackage

// File: rtl/strand_slot.sv
module strand_slot #(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [INSTR_W-1:0] load_instr,
  input  logic               drain,
  input  logic               mark,
  input  logic               unmark,
  output logic [INSTR_W-1:0] instr,
  output logic               eligible
);

  logic full_q;
  logic stall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      instr  <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      instr  <= load_instr;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
    end else if (unmark) begin
      stall_q <= 1'b0;
    end else if (mark) begin
      stall_q <= 1'b1;
    end
  end

  assign eligible = full_q & ~stall_q;

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N     = 4,
  parameter int SID_W = 2
) (
  input  logic [N-1:0]     elig,
  input  logic [SID_W-1:0] ptr,
  output logic             any,
  output logic [SID_W-1:0] pick
);

  // scan offsets from far to near so the nearest ready strand wins last
  always_comb begin
    int idx;
    any  = 1'b0;
    pick = '0;
    idx  = 0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(ptr) + k) % N;
      if (elig[idx]) begin
        any  = 1'b1;
        pick = SID_W'(idx);
      end
    end
  end

endmodule

// File: rtl/strand_switch.sv
module strand_switch
  import strand_switch_pkg::*;
#(
  parameter int NUM_STRANDS = DEF_STRANDS,
  parameter int INSTR_W     = DEF_INSTR_W,
  localparam int SID_W      = $clog2(NUM_STRANDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_valid,
  input  logic [SID_W-1:0]   fill_sid,
  input  logic [INSTR_W-1:0] fill_instr,
  input  logic               stall_set_valid,
  input  logic [SID_W-1:0]   stall_set_sid,
  input  logic               done_valid,
  input  logic [SID_W-1:0]   done_sid,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [SID_W-1:0]   dec_sid,
  output logic [INSTR_W-1:0] dec_instr,
  output logic               req_valid,
  output logic [SID_W-1:0]   req_sid
);

  logic [NUM_STRANDS-1:0] elig;
  logic [INSTR_W-1:0]     slot_instr [NUM_STRANDS];
  logic [SID_W-1:0]       ptr_q;
  logic [SID_W-1:0]       pick;
  logic                   any;
  logic                   issue;

  for (genvar g = 0; g < NUM_STRANDS; g++) begin : g_slot
    strand_slot #(.INSTR_W(INSTR_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .load      (fill_valid && (fill_sid == SID_W'(g))),
      .load_instr(fill_instr),
      .drain     (issue && (pick == SID_W'(g))),
      .mark      (stall_set_valid && (stall_set_sid == SID_W'(g))),
      .unmark    (done_valid && (done_sid == SID_W'(g))),
      .instr     (slot_instr[g]),
      .eligible  (elig[g])
    );
  end

  rr_picker #(.N(NUM_STRANDS), .SID_W(SID_W)) u_pick (
    .elig(elig),
    .ptr (ptr_q),
    .any (any),
    .pick(pick)
  );

  assign issue     = any && dec_ready;
  assign dec_valid = any;
  assign dec_sid   = pick;
  assign dec_instr = slot_instr[pick];
  assign req_valid = issue;
  assign req_sid   = pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (issue) begin
      ptr_q <= SID_W'(wrap_next(int'(pick), NUM_STRANDS));
    end
  end

endmodule

// File: rtl/strand_switch_chk.sv
module strand_switch_chk #(
  parameter int NUM_STRANDS = 4,
  parameter int INSTR_W     = 32,
  localparam int SID_W      = $clog2(NUM_STRANDS)
) (
  input logic               clk,
  input logic               rst,
  input logic               fill_valid,
  input logic [SID_W-1:0]   fill_sid,
  input logic [INSTR_W-1:0] fill_instr,
  input logic               stall_set_valid,
  input logic [SID_W-1:0]   stall_set_sid,
  input logic               done_valid,
  input logic [SID_W-1:0]   done_sid,
  input logic               dec_valid,
  input logic               dec_ready,
  input logic [SID_W-1:0]   dec_sid,
  input logic [INSTR_W-1:0] dec_instr,
  input logic               req_valid,
  input logic [SID_W-1:0]   req_sid
);

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dec_valid && !req_valid); // R1

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_ready && !fill_valid && !stall_set_valid && !done_valid
    |=> dec_valid && $stable(dec_sid) && $stable(dec_instr)); // R5

  AST_REQ_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> dec_valid && dec_ready && (req_sid == dec_sid)); // R6

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_ready && !(fill_valid && fill_sid == dec_sid)
    |=> !(dec_valid && dec_sid == $past(dec_sid))); // R7

  AST_STALL_SKIP: assert property (@(posedge clk) disable iff (rst)
    stall_set_valid && !(done_valid && done_sid == stall_set_sid)
    |=> !(dec_valid && dec_sid == $past(stall_set_sid))); // R8

endmodule

bind strand_switch strand_switch_chk #(
  .NUM_STRANDS(NUM_STRANDS),
  .INSTR_W    (INSTR_W)
) u_chk (.*);

// File: tb/test_strand_switch.sv
`timescale 1ns/1ps
module test_strand_switch;

  localparam int N  = 4;
  localparam int SW = 2;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fill_valid = 1'b0;
  logic [SW-1:0] fill_sid = '0;
  logic [IW-1:0] fill_instr = '0;
  logic          stall_set_valid = 1'b0;
  logic [SW-1:0] stall_set_sid = '0;
  logic          done_valid = 1'b0;
  logic [SW-1:0] done_sid = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [SW-1:0] dec_sid;
  logic [IW-1:0] dec_instr;
  logic          req_valid;
  logic [SW-1:0] req_sid;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  bit          m_full  [N];
  bit          m_stall [N];
  bit [IW-1:0] m_instr [N];
  int          m_ptr;

  always #2.5 clk = ~clk;

  strand_switch i_strand_switch (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_sid(fill_sid), .fill_instr(fill_instr),
    .stall_set_valid(stall_set_valid), .stall_set_sid(stall_set_sid),
    .done_valid(done_valid), .done_sid(done_sid),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_sid(dec_sid),
    .dec_instr(dec_instr), .req_valid(req_valid), .req_sid(req_sid)
  );

  function automatic int exp_pick();
    for (int k = 0; k < N; k++) begin
      int idx = (m_ptr + k) % N;
      if (m_full[idx] && !m_stall[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      m_full[s] = 0; m_stall[s] = 0; m_instr[s] = '0;
    end
    m_ptr = 0;
  endtask

  task automatic step(input bit fv, input int fs, input bit [IW-1:0] fi, input bit rdy,
                      input bit sv, input int ss, input bit dv, input int ds, input string tag);
    int  p;
    bit  xfer;
    @(negedge clk);
    fill_valid = fv; fill_sid = SW'(fs); fill_instr = fi; dec_ready = rdy;
    stall_set_valid = sv; stall_set_sid = SW'(ss); done_valid = dv; done_sid = SW'(ds);
    #1;
    p    = exp_pick();
    xfer = (p >= 0) && rdy;
    check({tag, " R3"}, "dec_valid", dec_valid, p >= 0);
    if (p >= 0) begin
      check({tag, " R4"}, "dec_sid", dec_sid, p);
      check({tag, " R2"}, "dec_instr", dec_instr, m_instr[p]);
    end
    check({tag, " R5"}, "req_valid", req_valid, xfer);
    if (xfer) check({tag, " R6"}, "req_sid", req_sid, p);
    // next state
    for (int s = 0; s < N; s++) begin
      if (fv && fs == s) begin m_full[s] = 1; m_instr[s] = fi; end
      else if (xfer && p == s) m_full[s] = 0;
      if (dv && ds == s) m_stall[s] = 0;
      else if (sv && ss == s) m_stall[s] = 1;
    end
    if (xfer) m_ptr = (p + 1) % N;
  endtask

  task automatic idle(input bit rdy, input string tag);
    step(0, 0, '0, rdy, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    idle(0, "R1 reset");
    // R1 pointer at 0: fill 3..0 under back-pressure, strand 0 first
    step(1, 3, 32'hA3, 0, 0, 0, 0, 0, "R2 fill");
    step(1, 2, 32'hA2, 0, 0, 0, 0, 0, "R2 fill");
    step(1, 1, 32'hA1, 0, 0, 0, 0, 0, "R2 fill");
    step(1, 0, 32'hA0, 0, 0, 0, 0, 0, "R2 fill");
    idle(0, "R1 first pick");
    idle(0, "R5 hold");
    // R4 / R7: drain in rotation order
    repeat (5) idle(1, "R4 rotation");
    // R7: fill with drain of the same strand
    step(1, 1, 32'hB1, 0, 0, 0, 0, 0, "R2 fill");
    step(1, 1, 32'hC1, 1, 0, 0, 0, 0, "R7 refill");
    idle(0, "R7 kept");
    idle(1, "R7 drain");
    idle(1, "R3 empty");
    // R10: overwrite a held word
    step(1, 3, 32'hD3, 0, 0, 0, 0, 0, "R10 load");
    step(1, 3, 32'hE3, 0, 0, 0, 0, 0, "R10 overwrite");
    idle(0, "R10 check");
    // R8: stall strand 3, then R9 set and clear together
    step(1, 2, 32'hF2, 0, 1, 3, 0, 0, "R8 mark");
    idle(0, "R8 skip");
    step(0, 0, '0, 0, 1, 2, 1, 2, "R9 clear wins");
    idle(0, "R9 result");
    step(0, 0, '0, 0, 0, 0, 1, 3, "R11 release");
    idle(1, "R11 rejoin");
    idle(1, "R11 rejoin");
    idle(1, "R3 drained");
    // random mix
    for (int c = 0; c < 4000; c++) begin
      step(($urandom % 2) == 0, $urandom % N, $urandom, ($urandom % 3) != 0,
           ($urandom % 7) == 0, $urandom % N, ($urandom % 5) == 0, $urandom % N,
           "random R8 R9 R10 R11");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule